// File: doc/BRIEF.md
# I2C Bus Start/Stop Condition Detector

This block watches the SCL and SDA lines of a multi-master I2C bus and decides when a START or a STOP condition has really happened. A START is a falling SDA edge while SCL is high, and a STOP is a rising SDA edge while SCL is high. An edge only counts when three timing limits are met. SCL must have been high long enough before the edge. SDA must have held its old level long enough before the edge. Both lines must stay put for a minimum time after the edge. A qualified START sets a bus-busy flag and a qualified STOP clears it. Each update comes with a one-cycle pulse that names the kind of condition.

The block runs on a clock at twice the rate of the bus timing clock. This lets half-cycle timing values be counted exactly. All values below are given in cycles of the block's own clock. A 5-bit timing code E scales the thresholds in standard mode, and a mode bit selects fixed, short thresholds instead. Zero and odd codes are not valid settings. The block turns them into the next higher even value and raises an error flag. Both bus inputs pass through two-flop synchronizers before any edge is seen.

Top module: `i2c_cond_detect`

## Requirements
- R1: A falling SDA edge with SCL held high that meets all qualification limits sets `bus_busy` and raises `start_pulse` for exactly one cycle. Both change at the (F+2)-th rising clock edge after the SDA input changes, where the first edge that samples the new level counts as the first. F = E+3 in standard mode.
- R2: A qualified rising SDA edge with SCL held high clears `bus_busy` and raises `stop_pulse` for one cycle, with the same F+2 edge timing as R1.
- R3: In standard mode (`fast_mode`=0) the limits are as follows, all counted on the synchronized lines:
  - SCL release time: 2E+2 cycles.
  - SDA setup time: E+2 cycles.
  - Hold time: E cycles.
  - Flag delay: F = E+3.
- R4: In fast mode (`fast_mode`=1) the timing code is ignored. The fixed values are release 8, setup 4, hold 4 and flag delay F = 7.
- R5: The effective code E is set as follows:
  - 2 when `timing_code` is 0.
  - `timing_code`+1 when `timing_code` is odd.
  - `timing_code` otherwise.
  
  `code_error` is 1 one cycle after an illegal code (0 or odd) is applied, and 0 one cycle after a legal code is applied.
- R6: An SDA edge that comes while SCL has been high for less than the release time produces no pulse and leaves `bus_busy` unchanged.
- R7: An SDA edge that comes less than the setup time after the previous SDA edge produces no pulse.
- R8: If SCL falls, or SDA returns to its old level, within the hold time after a candidate edge, the candidate is dropped. No pulse follows and `bus_busy` is unchanged.
- R9: SDA edges while SCL is low produce no pulse and leave `bus_busy` unchanged.
- R10: Synchronous active-high `rst` clears `bus_busy`, both pulses, `code_error`, all counters and any pending condition.
- R11: `start_pulse` and `stop_pulse` are never high together. `bus_busy` changes only in a cycle where the matching pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the bus timing clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| timing_code | input | 5 | Qualification timing code |
| fast_mode | input | 1 | 1 selects the fixed fast-mode timing |
| bus_busy | output | 1 | Set on START, cleared on STOP |
| start_pulse | output | 1 | One-cycle pulse when a START is accepted |
| stop_pulse | output | 1 | One-cycle pulse when a STOP is accepted |
| code_error | output | 1 | Registered flag for an illegal timing code |

## Verification
The assertions check every cycle that the busy flag moves only together with its matching pulse. They also check that the two pulses are exclusive, that each pulse lasts a single cycle, and that the error flag follows the legality of the code one cycle later. Only the bench scenarios can show the exact flag delay for each timing code and mode, the coercion of illegal codes, and the rejection of edges that break the release, setup or hold limits. The same holds for edges made while SCL is low.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    localparam int CODE_W = 5;
    localparam int CNT_W  = 7;

    // Fixed fast-mode thresholds in block clock cycles
    localparam int FAST_REL   = 8;
    localparam int FAST_SETUP = 4;
    localparam int FAST_HOLD  = 4;
    localparam int FAST_FLAG  = 7;

    typedef logic [CNT_W-1:0]  tick_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        tick_t rel;
        tick_t setup;
        tick_t hold;
        tick_t flag;
    } cond_times_t;

    typedef enum logic [1:0] {
        CND_NONE  = 2'd0,
        CND_START = 2'd1,
        CND_STOP  = 2'd2
    } cond_kind_t;

    function automatic logic code_illegal(code_t c);
        return (c == '0) || c[0];
    endfunction

    function automatic int code_effective(code_t c);
        if (c == '0)
            return 2;
        else if (c[0])
            return int'(c) + 1;
        else
            return int'(c);
    endfunction

    function automatic cond_times_t times_of(logic fast, code_t c);
        cond_times_t t;
        int e;
        e = code_effective(c);
        if (fast) begin
            t.rel   = tick_t'(FAST_REL);
            t.setup = tick_t'(FAST_SETUP);
            t.hold  = tick_t'(FAST_HOLD);
            t.flag  = tick_t'(FAST_FLAG);
        end else begin
            t.rel   = tick_t'(2 * e + 2);
            t.setup = tick_t'(e + 2);
            t.hold  = tick_t'(e);
            t.flag  = tick_t'(e + 3);
        end
        return t;
    endfunction

endpackage

// File: rtl/cond_sync.sv
module cond_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= {STAGES{RST_VAL}};
        else
            chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/cond_timing.sv
module cond_timing
    import i2c_cond_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fast_mode,
    input  code_t       timing_code,
    output cond_times_t times,
    output logic        code_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            times    <= '1;
            code_err <= 1'b0;
        end else begin
            times    <= times_of(fast_mode, timing_code);
            code_err <= code_illegal(timing_code);
        end
    end
endmodule

// File: rtl/cond_track.sv
module cond_track
    import i2c_cond_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_s,
    input  logic        sda_s,
    input  cond_times_t times,
    output logic        busy,
    output logic        start_p,
    output logic        stop_p
);
    localparam tick_t TICK_MAX = '1;

    logic       sda_d;
    tick_t      scl_cnt;
    tick_t      sda_cnt;
    logic       pend;
    cond_kind_t pkind;
    tick_t      pcnt;
    logic       sda_edge;
    logic       qualify;
    logic       want_sda;

    assign sda_edge = sda_s ^ sda_d;
    assign qualify  = sda_edge && scl_s &&
                      (scl_cnt >= times.rel) && (sda_cnt >= times.setup);
    assign want_sda = (pkind == CND_STOP);

    // Run lengths of SCL high and of stable SDA
    always_ff @(posedge clk) begin
        if (rst) begin
            sda_d   <= 1'b1;
            scl_cnt <= '0;
            sda_cnt <= '0;
        end else begin
            sda_d   <= sda_s;
            scl_cnt <= !scl_s ? '0 : (scl_cnt == TICK_MAX ? scl_cnt : scl_cnt + 1'b1);
            sda_cnt <= sda_edge ? '0 : (sda_cnt == TICK_MAX ? sda_cnt : sda_cnt + 1'b1);
        end
    end

    // Pending condition: hold check, then flag update after the delay
    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            pkind   <= CND_NONE;
            pcnt    <= '0;
            busy    <= 1'b0;
            start_p <= 1'b0;
            stop_p  <= 1'b0;
        end else begin
            start_p <= 1'b0;
            stop_p  <= 1'b0;
            if (qualify) begin
                pend  <= 1'b1;
                pkind <= sda_s ? CND_STOP : CND_START;
                pcnt  <= tick_t'(1);
            end else if (pend) begin
                if ((pcnt < times.hold) && (!scl_s || (sda_s != want_sda))) begin
                    pend  <= 1'b0;
                    pkind <= CND_NONE;
                end else if (pcnt == times.flag - 1'b1) begin
                    pend  <= 1'b0;
                    pkind <= CND_NONE;
                    busy  <= (pkind == CND_START);
                    start_p <= (pkind == CND_START);
                    stop_p  <= (pkind == CND_STOP);
                end else begin
                    pcnt <= pcnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
    import i2c_cond_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [CODE_W-1:0] timing_code,
    input  logic              fast_mode,
    output logic              bus_busy,
    output logic              start_pulse,
    output logic              stop_pulse,
    output logic              code_error
);
    logic        scl_s;
    logic        sda_s;
    cond_times_t times;

    cond_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
        .clk(clk), .rst(rst), .din(scl_in), .dout(scl_s)
    );

    cond_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
        .clk(clk), .rst(rst), .din(sda_in), .dout(sda_s)
    );

    cond_timing u_timing (
        .clk(clk), .rst(rst), .fast_mode(fast_mode),
        .timing_code(timing_code), .times(times), .code_err(code_error)
    );

    cond_track u_track (
        .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s), .times(times),
        .busy(bus_busy), .start_p(start_pulse), .stop_p(stop_pulse)
    );
endmodule

// File: rtl/i2c_cond_detect_chk.sv
module i2c_cond_detect_chk
    import i2c_cond_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] timing_code,
    input logic              bus_busy,
    input logic              start_pulse,
    input logic              stop_pulse,
    input logic              code_error
);
    a_r11_pulse_excl: assert property (@(posedge clk) disable iff (rst)
        !(start_pulse && stop_pulse));

    a_r1_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> bus_busy);

    a_r2_stop_clears_busy: assert property (@(posedge clk) disable iff (rst)
        stop_pulse |-> !bus_busy);

    a_r11_rise_with_start: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_busy) |-> start_pulse);

    a_r11_fall_with_stop: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_busy) |-> stop_pulse);

    a_r1_start_one_cycle: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    a_r2_stop_one_cycle: assert property (@(posedge clk) disable iff (rst)
        stop_pulse |=> !stop_pulse);

    a_r5_error_follows_code: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (code_error == $past((timing_code == '0) || timing_code[0])));
endmodule

bind i2c_cond_detect i2c_cond_detect_chk u_chk (
    .clk(clk), .rst(rst), .timing_code(timing_code), .bus_busy(bus_busy),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse), .code_error(code_error)
);

// File: tb/tb_i2c_cond_detect.sv
`timescale 1ns/1ps
module tb_i2c_cond_detect;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic [4:0] timing_code = 5'd24;
    logic       fast_mode = 1'b0;
    logic       bus_busy, start_pulse, stop_pulse, code_error;

    int n_checks = 0;
    int n_fail   = 0;
    int n_start  = 0;
    int n_stop   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    i2c_cond_detect dut (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .timing_code(timing_code), .fast_mode(fast_mode),
        .bus_busy(bus_busy), .start_pulse(start_pulse),
        .stop_pulse(stop_pulse), .code_error(code_error)
    );

    always @(negedge clk) begin
        if (start_pulse) n_start++;
        if (stop_pulse)  n_stop++;
    end

    // {fast, code, flag delay F, expected code_error}
    localparam int NV = 6;
    localparam logic [13:0] VEC [NV] = '{
        {1'b0, 5'd24, 7'd27, 1'b0},
        {1'b1, 5'd24, 7'd7,  1'b0},
        {1'b0, 5'd2,  7'd5,  1'b0},
        {1'b0, 5'd0,  7'd5,  1'b1},
        {1'b0, 5'd7,  7'd11, 1'b1},
        {1'b0, 5'd31, 7'd35, 1'b1}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive an SDA edge and check the flag update timing
    task automatic cond_edge(string req, logic new_sda, int f);
        logic old_busy;
        @(negedge clk);
        old_busy = bus_busy;
        sda_in = new_sda;
        repeat (f + 1) @(posedge clk);
        @(negedge clk);
        chk({req, " busy before delay"}, bus_busy, old_busy);
        chk({req, " no pulse before delay"}, {start_pulse, stop_pulse}, 2'b00);
        @(posedge clk);
        @(negedge clk);
        chk({req, " busy after delay"}, bus_busy, !new_sda);
        chk({req, " pulse"}, {start_pulse, stop_pulse}, new_sda ? 2'b01 : 2'b10);
        @(negedge clk);
        chk({req, " pulse one cycle"}, {start_pulse, stop_pulse}, 2'b00);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int s0, p0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        idle(3);
        // R10 reset state
        chk("R10 reset busy", bus_busy, 1'b0);
        chk("R10 reset pulses", {start_pulse, stop_pulse}, 2'b00);
        chk("R10 reset error", code_error, 1'b0);

        // Vector walk: R1 R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            fast_mode   = VEC[i][13];
            timing_code = VEC[i][12:8];
            idle(80);
            chk($sformatf("R5 code_error vec %0d", i), code_error, VEC[i][0]);
            cond_edge($sformatf("R1 R3 R4 start vec %0d", i), 1'b0, int'(VEC[i][7:1]));
            idle(80);
            cond_edge($sformatf("R2 R3 R4 stop vec %0d", i), 1'b1, int'(VEC[i][7:1]));
            idle(80);
        end

        fast_mode = 1'b0;
        timing_code = 5'd24;
        idle(80);

        // R9: SDA activity with SCL low
        s0 = n_start; p0 = n_stop;
        scl_in = 1'b0;
        idle(10);
        for (int k = 0; k < 4; k++) begin
            sda_in = ~sda_in;
            idle(20);
        end
        sda_in = 1'b1;
        idle(10);
        scl_in = 1'b1;
        idle(80);
        chk("R9 no pulses while SCL low", {n_start - s0, n_stop - p0}, 64'd0);
        chk("R9 busy unchanged", bus_busy, 1'b0);

        // R6: SDA falls too soon after SCL rises
        s0 = n_start;
        scl_in = 1'b0;
        idle(80);
        scl_in = 1'b1;
        idle(3);
        sda_in = 1'b0;
        idle(80);
        chk("R6 short release no start", n_start - s0, 0);
        chk("R6 busy unchanged", bus_busy, 1'b0);
        scl_in = 1'b0;
        idle(5);
        sda_in = 1'b1;
        idle(5);
        scl_in = 1'b1;
        idle(80);

        // R8: SCL falls within hold time
        s0 = n_start;
        sda_in = 1'b0;
        idle(3);
        scl_in = 1'b0;
        idle(80);
        chk("R8 SCL fall aborts start", n_start - s0, 0);
        chk("R8 busy unchanged after abort", bus_busy, 1'b0);
        sda_in = 1'b1;
        idle(5);
        scl_in = 1'b1;
        idle(80);

        // R7 and R8: STOP candidate undone by a quick SDA return
        cond_edge("R1 start before glitch", 1'b0, 27);
        idle(80);
        s0 = n_start; p0 = n_stop;
        sda_in = 1'b1;
        idle(3);
        sda_in = 1'b0;
        idle(80);
        chk("R8 SDA return aborts stop", n_stop - p0, 0);
        chk("R7 short setup no start", n_start - s0, 0);
        chk("R8 busy still set", bus_busy, 1'b1);

        // R10: reset while busy
        rst = 1'b1;
        idle(2);
        chk("R10 reset clears busy", bus_busy, 1'b0);
        chk("R10 reset clears pulses", {start_pulse, stop_pulse}, 2'b00);
        rst = 1'b0;
        idle(5);
        chk("R10 busy stays clear", bus_busy, 1'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule